// File: doc/BRIEF.md
# Fuse Shadow Register Bank

This block keeps a copy of a one-time-programmable fuse array in ordinary registers, so that software can read fuse contents over the register bus in one cycle. Each fuse word has its own bus address. After power-up the bank reads as zero. Software then starts a refresh through a set-only alias of the control register. A sequencer then fetches the per-word lock bits from the array, then fetches every data word in turn. For each fuse read it drives a strobe whose length comes from a software timing register, with a quiet gap before and after the strobe.

The fetched lock bits guard the bank. A word marked read-locked gives a fixed poison pattern instead of its contents. A word marked write-locked cannot be changed from the bus. Every attempt to break a lock sets a sticky error flag. A shadow write made while a refresh is running also sets the flag. Only one operation runs at a time: a refresh request made while a refresh is running is dropped.

Top module: `shadow_fuse_bank`

## Requirements
- R1: After reset, the control register (byte offset 0x000) reads zero, every shadow reads zero, and the timing register reads its parameter defaults.
- R2: Shadow word i sits at byte offset 0x400 + 0x10*i. A read returns data on bus_rdata in the cycle after the request. When the bank is idle and the word is not write-locked, a write stores the data. Any other address in the shadow window reads zero.
- R3: Writing a 1 in bit 10 to the set alias (offset 0x004) starts a refresh. While the refresh runs, reload_busy is high and control bits 8 (busy) and 10 (reload) read 1. All three stay high for exactly (NWORDS + NWORDS/16) * (2*relax + strobe) cycles.
- R4: For each fuse word the strobe is high for exactly `strobe` cycles, with `relax` idle cycles before it and `relax` idle cycles after it. The fuse address holds steady while the strobe is high. fuse_rdata is captured on the last strobe cycle.
- R5: A refresh reads the lock words first, at fuse addresses NWORDS upward, and then data words 0 to NWORDS-1. Afterwards each shadow holds its fuse value.
- R6: Lock word k with k < NWORDS/32 supplies read-lock bits: its bit j locks word 32k+j. Lock word NWORDS/32 + k supplies write-lock bits in the same way.
- R7: A read of a read-locked shadow returns 0xBADABADA and sets ERROR (control bit 9).
- R8: A write to a write-locked shadow sets ERROR and leaves the shadow unchanged.
- R9: A shadow write made during a refresh sets ERROR and does not update that shadow.
- R10: ERROR is sticky. Writing a 1 in bit 9 to the clear alias (offset 0x008) clears it. Writing bit 9 through the set alias has no effect.
- R11: A refresh request made during a refresh is ignored, so the busy time is not extended.
- R12: The timing register (offset 0x010) holds the strobe length in bits [5:0] and the relax length in bits [11:8]. A field written as zero reads back as zero but is used as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| reload_busy | output | 1 | Refresh in progress |
| fuse_strobe | output | 1 | Fuse array read strobe |
| fuse_addr | output | FA_W | Fuse word being read |
| fuse_rdata | input | 32 | Fuse array read data |

## Verification
The assertions check four behaviours on every cycle. The strobe is only active inside a refresh, and the fuse address stays still under it. Every locked-word read is answered with the poison pattern and raises the error flag. A shadow write during a refresh always raises the error flag. The flag can only fall after a clear-alias write. Other behaviours can only be shown by the bench's scenarios: the exact length of a refresh, the count and width of the strobe pulses, the order of lock and data fetches, the stored values after a refresh, the case where a shadow is left unchanged after a rejected write, and the case where a second refresh request is dropped.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;

    localparam logic [31:0] POISON_WORD = 32'hBADA_BADA;

    localparam int OFF_CTRL    = 'h000;
    localparam int OFF_SET     = 'h004;
    localparam int OFF_CLR     = 'h008;
    localparam int OFF_TIMING  = 'h010;
    localparam int OFF_SHADOW  = 'h400;

    localparam int BIT_BUSY    = 8;
    localparam int BIT_ERR     = 9;
    localparam int BIT_RELOAD  = 10;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_PRE,
        SEQ_STROBE,
        SEQ_POST
    } seq_state_e;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CTRL,
        ACC_SET,
        ACC_CLR,
        ACC_TIMING,
        ACC_SHADOW
    } acc_kind_e;

    typedef struct packed {
        logic [3:0] relax;
        logic [5:0] strobe;
    } timing_t;

    function automatic logic [5:0] eff_strobe(input logic [5:0] v);
        return (v == 6'd0) ? 6'd1 : v;
    endfunction

    function automatic logic [5:0] eff_relax(input logic [3:0] v);
        return (v == 4'd0) ? 6'd1 : {2'b00, v};
    endfunction

endpackage

// File: rtl/shadow_addr_decode.sv
module shadow_addr_decode
    import shadow_bank_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NWORDS = 128,
    localparam int IDX_W = $clog2(NWORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-5:0] wsel;

    always_comb begin
        rel  = addr - ADDR_W'(OFF_SHADOW);
        wsel = rel[ADDR_W-1:4];
        kind = ACC_NONE;
        idx  = rel[IDX_W+3:4];
        if (addr == ADDR_W'(OFF_CTRL))
            kind = ACC_CTRL;
        else if (addr == ADDR_W'(OFF_SET))
            kind = ACC_SET;
        else if (addr == ADDR_W'(OFF_CLR))
            kind = ACC_CLR;
        else if (addr == ADDR_W'(OFF_TIMING))
            kind = ACC_TIMING;
        else if (addr >= ADDR_W'(OFF_SHADOW) && rel[3:0] == 4'd0 &&
                 int'(wsel) < NWORDS)
            kind = ACC_SHADOW;
    end

endmodule

// File: rtl/shadow_reload_seq.sv
module shadow_reload_seq
    import shadow_bank_pkg::*;
#(
    parameter int NWORDS = 128,
    localparam int LOCKW = NWORDS / 16,
    localparam int TOTAL = NWORDS + LOCKW,
    localparam int SEQ_W = $clog2(TOTAL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  timing_t          timing,
    output logic             busy,
    output logic             fuse_strobe,
    output logic [SEQ_W-1:0] fuse_addr,
    input  logic [31:0]      fuse_rdata,
    output logic             cap_valid,
    output logic             cap_is_lock,
    output logic [SEQ_W-1:0] cap_idx,
    output logic [31:0]      cap_data
);

    seq_state_e       state;
    logic [5:0]       cnt;
    logic [SEQ_W-1:0] step;
    timing_t          tim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
            step  <= '0;
            tim_q <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (start) begin
                    state <= SEQ_PRE;
                    tim_q <= timing;
                    cnt   <= eff_relax(timing.relax) - 6'd1;
                    step  <= '0;
                end
                SEQ_PRE: if (cnt == 6'd0) begin
                    state <= SEQ_STROBE;
                    cnt   <= eff_strobe(tim_q.strobe) - 6'd1;
                end else begin
                    cnt <= cnt - 6'd1;
                end
                SEQ_STROBE: if (cnt == 6'd0) begin
                    state <= SEQ_POST;
                    cnt   <= eff_relax(tim_q.relax) - 6'd1;
                end else begin
                    cnt <= cnt - 6'd1;
                end
                SEQ_POST: if (cnt == 6'd0) begin
                    if (step == SEQ_W'(TOTAL - 1)) begin
                        state <= SEQ_IDLE;
                    end else begin
                        state <= SEQ_PRE;
                        step  <= step + 1'b1;
                        cnt   <= eff_relax(tim_q.relax) - 6'd1;
                    end
                end else begin
                    cnt <= cnt - 6'd1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        busy        = (state != SEQ_IDLE);
        fuse_strobe = (state == SEQ_STROBE);
        cap_valid   = (state == SEQ_STROBE) && (cnt == 6'd0);
        cap_is_lock = (step < SEQ_W'(LOCKW));
        cap_idx     = cap_is_lock ? step : step - SEQ_W'(LOCKW);
        fuse_addr   = cap_is_lock ? SEQ_W'(NWORDS) + step : step - SEQ_W'(LOCKW);
        cap_data    = fuse_rdata;
    end

endmodule

// File: rtl/shadow_store.sv
module shadow_store #(
    parameter int NWORDS = 128,
    localparam int IDX_W = $clog2(NWORDS),
    localparam int LOCKW = NWORDS / 16,
    localparam int HALF  = NWORDS / 32,
    localparam int LK_W  = $clog2(LOCKW),
    localparam int SEQ_W = $clog2(NWORDS + LOCKW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_valid,
    input  logic             cap_is_lock,
    input  logic [SEQ_W-1:0] cap_idx,
    input  logic [31:0]      cap_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_word,
    output logic             rd_locked,
    output logic             wr_locked
);

    logic [31:0]       mem   [NWORDS];
    logic [31:0]       lockw [LOCKW];
    logic [NWORDS-1:0] rlock_vec;
    logic [NWORDS-1:0] wlock_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
            for (int k = 0; k < LOCKW; k++) lockw[k] <= '0;
        end else if (cap_valid) begin
            if (cap_is_lock)
                lockw[cap_idx[LK_W-1:0]] <= cap_data;
            else
                mem[cap_idx[IDX_W-1:0]] <= cap_data;
        end else if (wr_en) begin
            mem[acc_idx] <= wr_data;
        end
    end

    for (genvar g = 0; g < HALF; g++) begin : g_lock_map
        assign rlock_vec[32*g +: 32] = lockw[g];
        assign wlock_vec[32*g +: 32] = lockw[HALF + g];
    end

    always_comb begin
        rd_word   = mem[acc_idx];
        rd_locked = rlock_vec[acc_idx];
        wr_locked = wlock_vec[acc_idx];
    end

endmodule

// File: rtl/shadow_fuse_bank.sv
module shadow_fuse_bank
    import shadow_bank_pkg::*;
#(
    parameter int         ADDR_W     = 12,
    parameter int         NWORDS     = 128,
    parameter logic [5:0] STROBE_DEF = 6'd8,
    parameter logic [3:0] RELAX_DEF  = 4'd2,
    localparam int        IDX_W      = $clog2(NWORDS),
    localparam int        LOCKW      = NWORDS / 16,
    localparam int        FA_W       = $clog2(NWORDS + LOCKW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              reload_busy,
    output logic              fuse_strobe,
    output logic [FA_W-1:0]   fuse_addr,
    input  logic [31:0]       fuse_rdata
);

    acc_kind_e        acc_kind;
    logic [IDX_W-1:0] acc_idx;
    timing_t          timing_q;
    logic             err_q;
    logic             start;
    logic             cap_valid;
    logic             cap_is_lock;
    logic [FA_W-1:0]  cap_idx;
    logic [31:0]      cap_data;
    logic [31:0]      rd_word;
    logic             rd_locked;
    logic             wr_locked;
    logic             shadow_wr_ok;
    logic             shadow_wr_bad;
    logic             rd_lock_hit;
    logic             err_clr;
    logic [31:0]      ctrl_word;

    shadow_addr_decode #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_dec (
        .addr (bus_addr),
        .kind (acc_kind),
        .idx  (acc_idx)
    );

    shadow_reload_seq #(.NWORDS(NWORDS)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .timing      (timing_q),
        .busy        (reload_busy),
        .fuse_strobe (fuse_strobe),
        .fuse_addr   (fuse_addr),
        .fuse_rdata  (fuse_rdata),
        .cap_valid   (cap_valid),
        .cap_is_lock (cap_is_lock),
        .cap_idx     (cap_idx),
        .cap_data    (cap_data)
    );

    shadow_store #(.NWORDS(NWORDS)) u_store (
        .clk         (clk),
        .rst         (rst),
        .cap_valid   (cap_valid),
        .cap_is_lock (cap_is_lock),
        .cap_idx     (cap_idx),
        .cap_data    (cap_data),
        .wr_en       (shadow_wr_ok),
        .acc_idx     (acc_idx),
        .wr_data     (bus_wdata),
        .rd_word     (rd_word),
        .rd_locked   (rd_locked),
        .wr_locked   (wr_locked)
    );

    always_comb begin
        start         = bus_wr && acc_kind == ACC_SET && bus_wdata[BIT_RELOAD] && !reload_busy;
        err_clr       = bus_wr && acc_kind == ACC_CLR && bus_wdata[BIT_ERR];
        shadow_wr_ok  = bus_wr && acc_kind == ACC_SHADOW && !reload_busy && !wr_locked;
        shadow_wr_bad = bus_wr && acc_kind == ACC_SHADOW && (reload_busy || wr_locked);
        rd_lock_hit   = bus_rd && acc_kind == ACC_SHADOW && rd_locked;
        ctrl_word             = '0;
        ctrl_word[BIT_BUSY]   = reload_busy;
        ctrl_word[BIT_ERR]    = err_q;
        ctrl_word[BIT_RELOAD] = reload_busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q     <= 1'b0;
            timing_q  <= '{relax: RELAX_DEF, strobe: STROBE_DEF};
            bus_rdata <= '0;
        end else begin
            if (shadow_wr_bad || rd_lock_hit)
                err_q <= 1'b1;
            else if (err_clr)
                err_q <= 1'b0;
            if (bus_wr && acc_kind == ACC_TIMING)
                timing_q <= '{relax: bus_wdata[11:8], strobe: bus_wdata[5:0]};
            if (bus_rd) begin
                case (acc_kind)
                    ACC_CTRL, ACC_SET, ACC_CLR: bus_rdata <= ctrl_word;
                    ACC_TIMING: bus_rdata <= {20'd0, timing_q.relax, 2'b00, timing_q.strobe};
                    ACC_SHADOW: bus_rdata <= rd_locked ? POISON_WORD : rd_word;
                    default:    bus_rdata <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/shadow_fuse_bank_sva.sv
module shadow_fuse_bank_sva
    import shadow_bank_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int FA_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              reload_busy,
    input logic              fuse_strobe,
    input logic [FA_W-1:0]   fuse_addr,
    input logic              err_q,
    input logic              rd_lock_hit,
    input acc_kind_e         acc_kind
);

    assert_strobe_in_reload_R4: assert property (@(posedge clk) disable iff (rst)
        fuse_strobe |-> reload_busy);

    assert_strobe_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (fuse_strobe && $past(fuse_strobe)) |-> $stable(fuse_addr));

    assert_poison_on_locked_read_R7: assert property (@(posedge clk) disable iff (rst)
        rd_lock_hit |=> (bus_rdata == POISON_WORD && err_q));

    assert_reload_write_error_R9: assert property (@(posedge clk) disable iff (rst)
        (reload_busy && bus_wr && acc_kind == ACC_SHADOW) |=> err_q);

    assert_error_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (err_q && !(bus_wr && bus_addr == ADDR_W'(OFF_CLR) && bus_wdata[BIT_ERR])) |=> err_q);

    assert_error_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd && bus_addr == ADDR_W'(OFF_CLR) && bus_wdata[BIT_ERR]) |=> !err_q);

endmodule

bind shadow_fuse_bank shadow_fuse_bank_sva #(.ADDR_W(ADDR_W), .FA_W(FA_W)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .reload_busy (reload_busy),
    .fuse_strobe (fuse_strobe),
    .fuse_addr   (fuse_addr),
    .err_q       (err_q),
    .rd_lock_hit (rd_lock_hit),
    .acc_kind    (acc_kind)
);

// File: tb/shadow_fuse_bank_test.sv
`timescale 1ns/1ps
module shadow_fuse_bank_test;

    localparam int ADDR_W = 12;
    localparam int NWORDS = 128;
    localparam int LOCKW  = NWORDS / 16;
    localparam int TOTAL  = NWORDS + LOCKW;
    localparam int FA_W   = $clog2(TOTAL);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              reload_busy;
    logic              fuse_strobe;
    logic [FA_W-1:0]   fuse_addr;
    logic [31:0]       fuse_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    shadow_fuse_bank #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) uut (
        .clk, .rst, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
        .reload_busy, .fuse_strobe, .fuse_addr, .fuse_rdata
    );

    // Fuse model: read lock on word 5, write lock on word 9.
    function automatic logic [31:0] fuse_val(input int a);
        if (a < NWORDS) return 32'hC0DE_0000 | a;
        if (a == NWORDS)     return 32'h1 << 5;
        if (a == NWORDS + 4) return 32'h1 << 9;
        return 32'h0;
    endfunction

    assign fuse_rdata = fuse_strobe ? fuse_val(int'(fuse_addr)) : 32'hDEAD_0000;

    function automatic logic [ADDR_W-1:0] waddr(input int i);
        return ADDR_W'('h400 + 16 * i);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // Start a refresh and measure it; optionally inject a shadow write and a second request.
    task automatic run_reload(input string req, input int s, input int r, input bit inject);
        int cycles = 0;
        int hi = 0;
        int pulses = 0;
        logic prev = 1'b0;
        bus_write(12'h004, 32'h400);
        while (reload_busy && cycles < 5000) begin
            cycles++;
            if (fuse_strobe) hi++;
            if (fuse_strobe && !prev) pulses++;
            prev = fuse_strobe;
            if (inject && cycles == 300) begin
                bus_wr = 1'b1; bus_addr = waddr(3); bus_wdata = 32'hFFFF_0003;
            end else if (inject && cycles == 301) begin
                bus_wr = 1'b1; bus_addr = 12'h004; bus_wdata = 32'h400;
            end else begin
                bus_wr = 1'b0;
            end
            @(negedge clk);
        end
        bus_wr = 1'b0;
        check({req, " busy length"}, cycles, TOTAL * (2 * r + s));
        check("R4 strobe high cycles", hi, TOTAL * s);
        check("R4 strobe pulse count", pulses, TOTAL);
    endtask

    task automatic test_reset();
        logic [31:0] d;
        bus_read(12'h000, d); check("R1 ctrl after reset", d, 32'h0);
        bus_read(12'h010, d); check("R1 timing after reset", d, 32'h0000_0208);
        bus_read(waddr(3), d); check("R1 shadow after reset", d, 32'h0);
    endtask

    task automatic test_rw();
        logic [31:0] d;
        bus_write(waddr(0), 32'h1234_5678);
        bus_write(waddr(127), 32'h8765_4321);
        bus_read(waddr(0), d);   check("R2 shadow 0 write/read", d, 32'h1234_5678);
        bus_read(waddr(127), d); check("R2 shadow 127 write/read", d, 32'h8765_4321);
        bus_read(12'h404, d);    check("R2 misaligned reads zero", d, 32'h0);
        bus_read(12'h000, d);    check("R2 no error", d, 32'h0);
    endtask

    task automatic test_timing();
        logic [31:0] d;
        bus_write(12'h010, 32'h0000_0000);
        bus_read(12'h010, d); check("R12 zero timing reads back", d, 32'h0);
        run_reload("R12 zero timing", 1, 1, 1'b0);
        bus_write(12'h010, 32'hFFFF_F102);
        bus_read(12'h010, d); check("R12 timing fields", d, 32'h0000_0102);
    endtask

    task automatic test_reload();
        logic [31:0] d;
        run_reload("R3", 2, 1, 1'b0);
        bus_read(12'h000, d);    check("R3 ctrl idle after refresh", d, 32'h0);
        bus_read(waddr(0), d);   check("R5 shadow 0 refreshed", d, fuse_val(0));
        bus_read(waddr(127), d); check("R5 shadow 127 refreshed", d, fuse_val(127));
        bus_read(waddr(37), d);  check("R6 word 37 unlocked", d, fuse_val(37));
        bus_read(waddr(9), d);   check("R6 write-locked word readable", d, fuse_val(9));
    endtask

    task automatic test_locks();
        logic [31:0] d;
        bus_read(waddr(5), d);  check("R7 poison on read-locked", d, 32'hBADA_BADA);
        bus_read(12'h000, d);   check("R7 error set", d, 32'h200);
        bus_write(12'h004, 32'h200);
        bus_read(12'h000, d);   check("R10 set alias cannot clear", d, 32'h200);
        bus_write(12'h008, 32'h200);
        bus_read(12'h000, d);   check("R10 clear alias clears", d, 32'h0);
        bus_write(12'h004, 32'h200);
        bus_read(12'h000, d);   check("R10 set alias cannot set", d, 32'h0);
        bus_write(waddr(9), 32'h0BAD_0009);
        bus_read(12'h000, d);   check("R8 error on locked write", d, 32'h200);
        bus_read(waddr(9), d);  check("R8 locked word unchanged", d, fuse_val(9));
        bus_write(waddr(4), 32'h0000_0044);
        bus_read(waddr(4), d);  check("R8 neighbour writable", d, 32'h0000_0044);
        bus_write(12'h008, 32'h200);
    endtask

    task automatic test_reload_write();
        logic [31:0] d;
        run_reload("R11 second request ignored", 2, 1, 1'b1);
        bus_read(12'h000, d);  check("R9 error on write during refresh", d, 32'h200);
        bus_read(waddr(3), d); check("R9 shadow not updated", d, fuse_val(3));
        bus_read(waddr(4), d); check("R5 refresh restores word 4", d, fuse_val(4));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_rw();
        test_timing();
        test_reload();
        test_locks();
        test_reload_write();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule